// File: doc/BRIEF.md
# Block-Granular Result FIFO Readout

This block queues touch-conversion results as 4-byte blocks and serves them to a serial host that reads a single FIFO register address. The address does not autoincrement, so one read command can stream through several queued blocks back to back. The conversion engine pushes one block per completed conversion. The block order is X high byte, X low byte, Y high byte, Y low byte. On the read side, the serial slave gives a transfer-active level, a one-cycle pulse for every serial clock rising edge, and the assembled command byte. The block answers with the byte that is being shifted out at that point.

Occupancy is counted in whole blocks. A block is consumed early in the transfer of its first byte. The trigger is the second serial clock rising edge after that byte begins to drive. A read aborted after that edge has still used up the block. A read aborted before it leaves the block queued, and the block is sent again on the next read. The block latches the block being shifted when that block starts, so the retire does not disturb the bytes still to be sent.

Top module: `fifo_blk_readout`

## Requirements
- R1: After reset, empty_o is 1, and full_o, ovf_o, drive_o and byte_o are 0.
- R2: Blocks are read out in push order. Within a block the bytes follow this order: blk_i[31:24] (X high), blk_i[23:16] (X low), blk_i[15:8] (Y high), blk_i[7:0] (Y low).
- R3: full_o is 1 when DEPTH blocks are held. A push in a cycle where full_o is 1 is dropped, even if a retire happens in the same cycle. Such a push sets ovf_o, and ovf_o stays set until reset. full_o and empty_o are never both 1.
- R4: The data phase starts only when the command byte cmd_i, sampled at the 8th rise of a transfer, equals {7'h50, 1'b1}. For any other command, drive_o stays 0, byte_o stays 0 and no block is retired.
- R5: After rise n (n >= 8) of a FIFO read, drive_o is 1 and byte_o is byte ((n-8)/8) mod 4 of block (n-8)/32 of that read. When drive_o is 0, byte_o is 0.
- R6: There is no autoincrement. A new block is presented every 32 rises, starting at rises 8, 40, 72 and so on, for as long as rises continue.
- R7: Block b of a read is retired at rise 10+32b, provided the FIFO was not empty at rise 8+32b. The bytes of block b that remain are still the latched bytes after the retire.
- R8: If the transfer ends before rise 10+32b, block b stays queued and is sent again on the next read. If it ends after that rise, block b is gone.
- R9: A block slot that starts while the FIFO is empty sends four 0x00 bytes and retires nothing. This holds even if a push lands before the retire rise.
- R10: rise_i has no effect while xfer_i is 0. Lowering xfer_i returns the sequence to the command phase, with drive_o and byte_o at 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Append one result block |
| blk_i | input | 32 | Result block, X high byte in the top bits |
| xfer_i | input | 1 | Serial transfer active (chip select asserted) |
| rise_i | input | 1 | One-cycle pulse per serial clock rising edge |
| cmd_i | input | 8 | Command byte, valid at the 8th rise |
| byte_o | output | 8 | Byte currently being shifted out |
| drive_o | output | 1 | Data phase of a FIFO read is active |
| full_o | output | 1 | FIFO holds DEPTH blocks |
| empty_o | output | 1 | FIFO holds no block |
| ovf_o | output | 1 | Sticky flag for a push that was dropped |

## Verification
The bench aborts reads one rise before and exactly at the retire rise. A design that retired at block end or on the wrong edge would then lose the block or send it twice. It pushes into an empty FIFO between a block slot's start and its retire point. A design that sampled occupancy late would then send that block twice or retire it silently. It fills past DEPTH and also reads across several blocks in one command, so dropped-push errors, wrong byte lanes and missing block rollover after 32 rises show up in the byte stream. Wrong read commands and stray rises with the transfer idle test that the command decode does not start or shift the sequence.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int BYTE_W    = 8;
  localparam int BLK_BYTES = 4;
  localparam int BLK_W     = BYTE_W * BLK_BYTES;
  localparam int BLK_BITS  = BLK_W;
  localparam int CMD_BITS  = 8;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BLK_W-1:0]  blk_t;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_SKIP = 2'd2
  } phase_e;
endpackage

// File: rtl/fbr_store.sv
module fbr_store
  import fbr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  blk_t blk_i,
  input  logic pop_i,
  output blk_t head_o,
  output logic full_o,
  output logic empty_o,
  output logic ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  blk_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  // full is judged before any same-cycle retire
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= blk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_nxt(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
  import fbr_pkg::*;
#(
  parameter logic [6:0] FIFO_ADDR  = 7'h50,
  parameter int         RETIRE_OFS = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          xfer_i,
  input  logic                          rise_i,
  input  logic [CMD_BITS-1:0]           cmd_i,
  input  logic                          empty_i,
  output logic                          load_o,
  output logic                          retire_o,
  output logic                          drive_o,
  output logic [$clog2(BLK_BYTES)-1:0]  lane_o
);
  localparam int BW = $clog2(BLK_BITS);
  localparam int LW = $clog2(BLK_BYTES);
  localparam int CCW = $clog2(CMD_BITS);
  localparam logic [CMD_BITS-1:0] CMD_RD = {FIFO_ADDR, 1'b1};

  phase_e         phase;
  logic [CCW-1:0] cmd_cnt;
  logic [BW-1:0]  bit_cnt;
  logic           cur_vld;
  logic           step, cmd_last, blk_last;

  assign step     = xfer_i && rise_i;
  assign cmd_last = (cmd_cnt == CCW'(CMD_BITS - 1));
  assign blk_last = (bit_cnt == BW'(BLK_BITS - 1));

  always_comb begin
    load_o   = 1'b0;
    retire_o = 1'b0;
    if (step) begin
      unique case (phase)
        PH_CMD:  load_o = cmd_last && (cmd_i == CMD_RD);
        PH_DATA: begin
          load_o   = blk_last;
          retire_o = cur_vld && (bit_cnt == BW'(RETIRE_OFS - 1));
        end
        default: ;
      endcase
    end
  end

  assign drive_o = (phase == PH_DATA);
  assign lane_o  = bit_cnt[BW-1 -: LW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase   <= PH_CMD;
      cmd_cnt <= '0;
      bit_cnt <= '0;
      cur_vld <= 1'b0;
    end else if (!xfer_i) begin
      phase   <= PH_CMD;
      cmd_cnt <= '0;
      bit_cnt <= '0;
      cur_vld <= 1'b0;
    end else if (step) begin
      unique case (phase)
        PH_CMD: begin
          if (cmd_last) begin
            phase   <= (cmd_i == CMD_RD) ? PH_DATA : PH_SKIP;
            bit_cnt <= '0;
          end else begin
            cmd_cnt <= cmd_cnt + CCW'(1);
          end
        end
        PH_DATA: bit_cnt <= blk_last ? '0 : bit_cnt + BW'(1);
        default: ;
      endcase
      if (load_o) cur_vld <= !empty_i;
    end
  end
endmodule

// File: rtl/fbr_hold.sv
module fbr_hold
  import fbr_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         empty_i,
  input  blk_t                         head_i,
  input  logic [$clog2(BLK_BYTES)-1:0] lane_i,
  input  logic                         drive_i,
  output byte_t                        byte_o
);
  blk_t  cur;
  byte_t lanes [BLK_BYTES];

  // latch the block at slot start so a retire does not disturb its tail
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur <= '0;
    else if (load_i) cur <= empty_i ? '0 : head_i;
  end

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    assign lanes[g] = cur[BLK_W-1-g*BYTE_W -: BYTE_W];
  end

  assign byte_o = drive_i ? lanes[lane_i] : '0;
endmodule

// File: rtl/fifo_blk_readout.sv
module fifo_blk_readout
  import fbr_pkg::*;
#(
  parameter int         DEPTH      = 8,
  parameter logic [6:0] FIFO_ADDR  = 7'h50,
  parameter int         RETIRE_OFS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [31:0] blk_i,
  input  logic        xfer_i,
  input  logic        rise_i,
  input  logic [7:0]  cmd_i,
  output logic [7:0]  byte_o,
  output logic        drive_o,
  output logic        full_o,
  output logic        empty_o,
  output logic        ovf_o
);
  localparam int LW = $clog2(BLK_BYTES);

  blk_t          head;
  logic          load, retire;
  logic [LW-1:0] lane;

  fbr_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .blk_i   (blk_i),
    .pop_i   (retire),
    .head_o  (head),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o)
  );

  fbr_seq #(.FIFO_ADDR(FIFO_ADDR), .RETIRE_OFS(RETIRE_OFS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .xfer_i   (xfer_i),
    .rise_i   (rise_i),
    .cmd_i    (cmd_i),
    .empty_i  (empty_o),
    .load_o   (load),
    .retire_o (retire),
    .drive_o  (drive_o),
    .lane_o   (lane)
  );

  fbr_hold u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .empty_i (empty_o),
    .head_i  (head),
    .lane_i  (lane),
    .drive_i (drive_o),
    .byte_o  (byte_o)
  );
endmodule

// File: rtl/fifo_blk_readout_chk.sv
module fifo_blk_readout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       push_i,
  input logic       xfer_i,
  input logic [7:0] byte_o,
  input logic       drive_o,
  input logic       full_o,
  input logic       empty_o,
  input logic       ovf_o,
  input logic       retire_i
);
  AST_OVF_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |=> ovf_o); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R3
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R3
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> !drive_o && byte_o == 8'h00); // R10
  AST_RETIRE_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> !empty_o); // R7
  AST_RETIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> !retire_i); // R7
  AST_RETIRE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> xfer_i && drive_o); // R9
endmodule

bind fifo_blk_readout fifo_blk_readout_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .push_i   (push_i),
  .xfer_i   (xfer_i),
  .byte_o   (byte_o),
  .drive_o  (drive_o),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .ovf_o    (ovf_o),
  .retire_i (retire)
);

// File: tb/fifo_blk_readout_tb_top.sv
module fifo_blk_readout_tb_top;
  localparam int DEPTH = 8;
  localparam logic [7:0] CMD_OK = {7'h50, 1'b1};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [31:0] blk_i = '0;
  logic        xfer_i = 1'b0;
  logic        rise_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [7:0]  byte_o;
  logic        drive_o, full_o, empty_o, ovf_o;

  int          checks = 0;
  int          fails = 0;
  logic [31:0] q[$];
  logic        m_ovf = 1'b0;

  always #10 clk_i = ~clk_i;

  fifo_blk_readout dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .blk_i(blk_i),
    .xfer_i(xfer_i), .rise_i(rise_i), .cmd_i(cmd_i), .byte_o(byte_o),
    .drive_o(drive_o), .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] b, input int ofs);
    return b[8*(3 - ofs/8) +: 8];
  endfunction

  // model push, full judged before any same-cycle retire
  function automatic void model_push(input logic [31:0] d, input bit was_full);
    if (was_full) m_ovf = 1'b1;
    else q.push_back(d);
  endfunction

  task automatic flags_chk(input string req);
    chk(empty_o == (q.size() == 0), req, "empty_o", empty_o, q.size() == 0);
    chk(full_o == (q.size() == DEPTH), req, "full_o", full_o, q.size() == DEPTH);
    chk(ovf_o == m_ovf, req, "ovf_o", ovf_o, m_ovf);
  endtask

  task automatic do_push(input logic [31:0] d);
    @(negedge clk_i);
    push_i = 1'b1;
    blk_i  = d;
    model_push(d, q.size() == DEPTH);
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  // nr rises; optional push coinciding with rise push_at
  task automatic do_read(input int nr, input logic [7:0] cmd, input string req,
                         input int push_at, input logic [31:0] pd);
    logic [31:0] cur = '0;
    bit          cur_vld = 1'b0;
    bit          data_ok = (cmd == CMD_OK);
    @(negedge clk_i);
    xfer_i = 1'b1;
    cmd_i  = cmd;
    @(negedge clk_i);
    for (int n = 1; n <= nr; n++) begin
      bit was_full = (q.size() == DEPTH);
      logic [7:0] eb = 8'h00;
      bit ed = 1'b0;
      rise_i = 1'b1;
      if (n == push_at) begin push_i = 1'b1; blk_i = pd; end
      if (data_ok && n >= 8) begin
        int ofs = (n - 8) % 32;
        if (ofs == 0) begin
          cur_vld = (q.size() > 0);
          cur = cur_vld ? q[0] : 32'h0;
        end
        if (ofs == 2 && cur_vld) void'(q.pop_front());
        eb = exp_byte(cur, ofs);
        ed = 1'b1;
      end
      if (n == push_at) model_push(pd, was_full);
      @(negedge clk_i);
      rise_i = 1'b0;
      push_i = 1'b0;
      chk(drive_o == ed, req, $sformatf("drive_o rise %0d", n), drive_o, ed);
      chk(byte_o == eb, req, $sformatf("byte_o rise %0d", n), byte_o, eb);
      @(negedge clk_i);
    end
    xfer_i = 1'b0;
    @(negedge clk_i);
    chk(!drive_o && byte_o == 8'h00, "R10", "idle after xfer", {drive_o, byte_o}, 0);
    flags_chk(req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk_i);
    chk(empty_o && !full_o && !ovf_o && !drive_o && byte_o == 0, "R1", "in reset",
        {empty_o, full_o, ovf_o, drive_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(empty_o && !full_o && !ovf_o && !drive_o && byte_o == 0, "R1", "after reset",
        {empty_o, full_o, ovf_o, drive_o}, 4'b1000);

    // R2 R5 R6: three blocks in one read, then an empty slot
    do_push(32'h1122_3344);
    do_push(32'hA5B6_C7D8);
    do_push(32'h0F1E_2D3C);
    do_read(8 + 128, CMD_OK, "R6", 0, 0);

    // R8: abort one rise before retire, then exactly at retire
    do_push(32'hDEAD_BEEF);
    do_push(32'hCAFE_F00D);
    do_read(9, CMD_OK, "R8", 0, 0);
    chk(q.size() == 2, "R8", "model kept block", q.size(), 2);
    do_read(10, CMD_OK, "R8", 0, 0);
    do_read(41, CMD_OK, "R7", 0, 0);
    do_read(42, CMD_OK, "R7", 0, 0);

    // R4: wrong commands
    do_push(32'h5566_7788);
    do_read(48, {7'h50, 1'b0}, "R4", 0, 0);
    do_read(48, {7'h51, 1'b1}, "R4", 0, 0);

    // R10: stray rises with xfer idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i); rise_i = 1'b1;
      @(negedge clk_i); rise_i = 1'b0;
    end
    chk(!drive_o, "R10", "stray rises", drive_o, 0);
    do_read(40, CMD_OK, "R10", 0, 0);

    // R9: empty slot, push lands before retire rise
    do_read(40, CMD_OK, "R9", 9, 32'h0BAD_CAFE);
    chk(q.size() == 1, "R9", "pushed block kept", q.size(), 1);
    do_read(40, CMD_OK, "R9", 0, 0);

    // R3: overfill
    for (int i = 0; i < DEPTH + 2; i++) do_push(32'h1000_0000 + i);
    flags_chk("R3");
    // R3: push on full coinciding with retire is dropped
    do_read(12, CMD_OK, "R3", 10, 32'h7777_7777);
    do_read(8 + 32 * DEPTH, CMD_OK, "R2", 0, 0);

    // constrained random
    for (int it = 0; it < 220; it++) begin
      int act = $urandom_range(0, 9);
      if (act < 4) begin
        do_push($urandom());
      end else begin
        logic [7:0] c = ($urandom_range(0, 7) == 0) ? 8'($urandom()) : CMD_OK;
        int nr = $urandom_range(1, 110);
        int pa = ($urandom_range(0, 3) == 0) ? $urandom_range(1, nr) : 0;
        do_read(nr, c, "R5", pa, $urandom());
      end
    end

    summary();
    $finish;
  end
endmodule